// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Lookup

This block holds the tag, valid and data storage of a small two-way set-associative cache. It answers read lookups in the same cycle. A 16-bit byte address is split into a tag, a set index and a byte offset. The two entries of the indexed set are checked in parallel, and the block reports hit or miss, the way that hit, and one byte of the matching 8-byte line.

A separate fill port writes a whole line, with its tag, into the set named by the fill address. An empty way in that set is always used first, so a resident block is never pushed out while there is still room. When both ways are occupied, one recency bit per set picks the way to replace. The surrounding controller fetches lines from the next memory level and must not fill a block that is already resident.

Top module: `cache2w_lookup`

## Requirements
- R1: Address fields are fixed. Byte offset = bits 2:0, set index = bits 10:3, tag = bits 15:11. There are 256 sets and the tag is 5 bits.
- R2: After reset every valid bit is 0, so every lookup misses.
- R3: A lookup with `lk_req`=1 hits when a way of the indexed set is valid and its stored tag equals the address tag. `lk_way` gives that way (0 or 1). `lk_way` is 0 when there is no hit.
- R4: A way whose valid bit is 0 never produces a hit, whatever its stored tag holds.
- R5: `lk_miss` = `lk_req` and no hit. Hit and miss are never both 1, and both are 0 when `lk_req`=0.
- R6: On a hit, `lk_byte` is bits [8k+7:8k] of the matching line, where k is the byte offset.
- R7: `lk_byte` is 0 whenever `lk_hit` is 0.
- R8: A fill writes the line, the tag and valid=1 in one clock edge. A lookup in the next cycle sees the new contents.
- R9: A lookup in the same cycle as a fill to the same set sees the contents from before the fill.
- R10: A fill uses way 0 if it is invalid, else way 1 if it is invalid. A valid block is not replaced while its set still has an invalid way.
- R11: When both ways are valid, the fill replaces the way that is least recently used. Every hit and every fill marks its way as most recent. If a hit and a fill touch the same set in one cycle, the fill's update wins. After reset, way 0 is the one to replace.
- R12: At most one way drives the line output in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_addr | input | 16 | Lookup byte address |
| fill_en | input | 1 | Write a line into the set of `fill_addr` |
| fill_addr | input | 16 | Fill address (tag and set index are used) |
| fill_line | input | 64 | Line data; byte k sits at bits [8k+7:8k] |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup requested and missed |
| lk_way | output | 1 | Way that hit |
| lk_byte | output | 8 | Selected byte, or 0 when there is no hit |

## Verification
Directed sequences cover several cases. A first fill lands in an empty way, and a second block of the same set goes to the free way without displacing the first. With both ways full, a hit changes which way the next fill replaces. A fill and a lookup to the same set in one cycle separate the old view from the new one. The all-ones address shows that the fields sit at the stated bit positions, and never-filled sets show that the valid bit gates matching. A random phase then confines traffic to four sets and three tags, so that evictions, repeated hits and hit-plus-fill collisions occur often. These runs are checked against a behavioural model in every cycle.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
  parameter int ADDR_W = 16;
  parameter int OFF_W  = 3;
  parameter int IDX_W  = 8;
  parameter int WAYS   = 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = 8 << OFF_W;
  localparam int SETS   = 1 << IDX_W;

  function automatic logic [OFF_W-1:0] addr_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] line,
                                           input logic [OFF_W-1:0] off);
    return line[8*off +: 8];
  endfunction
endpackage

// File: rtl/c2w_way_store.sv
module c2w_way_store #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 5,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic              wr_valid
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = line_q[rd_idx];
  assign wr_valid = valid_q[wr_idx];

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]); // R8
  AST_FILL_STORES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tag_q[$past(wr_idx)] == $past(wr_tag)); // R8
endmodule

// File: rtl/c2w_lru.sv
module c2w_lru #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [1:0]       fill_vld,
  output logic             victim
);
  localparam int SETS = 1 << IDX_W;

  // one bit per set: the way to replace next
  logic [SETS-1:0] lru_q;

  always_comb begin
    if (!fill_vld[0])      victim = 1'b0;
    else if (!fill_vld[1]) victim = 1'b1;
    else                   victim = lru_q[fill_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lru_q <= '0;
    else begin
      if (hit_en)  lru_q[hit_idx]  <= ~hit_way;
      if (fill_en) lru_q[fill_idx] <= ~victim;  // fill overrides hit
    end
  end

  AST_KEEP_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_vld != 2'b11) |-> !fill_vld[victim]); // R10
  AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> lru_q[$past(fill_idx)] != $past(victim)); // R11
endmodule

// File: rtl/cache2w_lookup.sv
module cache2w_lookup
  import c2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [LINE_W-1:0] fill_line,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_way,
  output logic [7:0]        lk_byte
);
  logic [IDX_W-1:0]  lk_idx, fill_idx;
  logic [TAG_W-1:0]  lk_tag, fill_tag;
  logic [OFF_W-1:0]  lk_off;
  logic [WAYS-1:0]   rd_valid, way_eq, way_sel, wr_en, fill_vld;
  logic [TAG_W-1:0]  rd_tag  [WAYS];
  logic [LINE_W-1:0] rd_line [WAYS];
  logic [LINE_W-1:0] sel_line;
  logic              victim;

  assign lk_idx   = addr_idx(lk_addr);
  assign lk_tag   = addr_tag(lk_addr);
  assign lk_off   = addr_off(lk_addr);
  assign fill_idx = addr_idx(fill_addr);
  assign fill_tag = addr_tag(fill_addr);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    c2w_way_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_valid (rd_valid[w]),
      .rd_tag   (rd_tag[w]),
      .rd_line  (rd_line[w]),
      .wr_en    (wr_en[w]),
      .wr_idx   (fill_idx),
      .wr_tag   (fill_tag),
      .wr_line  (fill_line),
      .wr_valid (fill_vld[w])
    );
    assign way_eq[w]  = (rd_tag[w] == lk_tag);
    // per-way qualified match steers data; never the combined hit
    assign way_sel[w] = lk_req & rd_valid[w] & way_eq[w];
    assign wr_en[w]   = fill_en & (victim == w[0]);
  end

  always_comb begin
    sel_line = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_sel[w]) sel_line = sel_line | rd_line[w];
  end

  assign lk_hit  = |way_sel;
  assign lk_miss = lk_req & ~lk_hit;
  assign lk_way  = way_sel[1];
  assign lk_byte = lk_hit ? pick_byte(sel_line, lk_off) : 8'h00;

  c2w_lru #(.IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_en   (lk_hit),
    .hit_idx  (lk_idx),
    .hit_way  (lk_way),
    .fill_en  (fill_en),
    .fill_idx (fill_idx),
    .fill_vld (fill_vld),
    .victim   (victim)
  );

  AST_ONE_WAY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_sel)); // R12
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> (!lk_hit && !lk_miss)); // R5
  AST_MISS_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_byte == 8'h00); // R7
endmodule

// File: tb/tb_cache2w_lookup.sv
module tb_cache2w_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [15:0] lk_addr = '0;
  logic        fill_en = 1'b0;
  logic [15:0] fill_addr = '0;
  logic [63:0] fill_line = '0;
  logic        lk_hit, lk_miss, lk_way;
  logic [7:0]  lk_byte;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  bit        mv   [2][256];
  bit [4:0]  mt   [2][256];
  bit [63:0] ml   [2][256];
  bit        mlru [256];

  always #4 clk = ~clk;

  cache2w_lookup dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_line(fill_line),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_way(lk_way), .lk_byte(lk_byte)
  );

  function automatic bit [15:0] mk(input int tg, input int idx, input int off);
    return {tg[4:0], idx[7:0], off[2:0]};
  endfunction

  function automatic bit [63:0] pat(input int seed);
    bit [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = 8'(seed * 8 + k + 1);
    return r;
  endfunction

  function automatic bit resident(input bit [15:0] a);
    for (int w = 0; w < 2; w++)
      if (mv[w][a[10:3]] && mt[w][a[10:3]] == a[15:11]) return 1;
    return 0;
  endfunction

  task automatic cyc(input bit req, input bit [15:0] a, input bit fe,
                     input bit [15:0] fa, input bit [63:0] fl, input string rq);
    bit eh, em, ew, v;
    bit [7:0] eb;
    int idx, fi;
    lk_req = req; lk_addr = a; fill_en = fe; fill_addr = fa; fill_line = fl;
    #1;
    idx = a[10:3]; eh = 0; ew = 0;
    for (int w = 0; w < 2; w++)
      if (req && mv[w][idx] && mt[w][idx] == a[15:11]) begin eh = 1; ew = w[0]; end
    em = req && !eh;
    eb = eh ? ml[ew][idx][8*a[2:0] +: 8] : 8'h00;
    n_cmp++;
    if (lk_hit !== eh || lk_miss !== em || lk_way !== ew || lk_byte !== eb) begin
      n_bad++;
      $display("FAIL %s: addr=%h got hit=%b miss=%b way=%b byte=%h expected hit=%b miss=%b way=%b byte=%h",
               rq, a, lk_hit, lk_miss, lk_way, lk_byte, eh, em, ew, eb);
    end
    @(posedge clk);
    fi = fa[10:3];
    v = !mv[0][fi] ? 1'b0 : (!mv[1][fi] ? 1'b1 : mlru[fi]);
    if (eh) mlru[idx] = ~ew;
    if (fe) begin
      mv[v][fi] = 1; mt[v][fi] = fa[15:11]; ml[v][fi] = fl; mlru[fi] = ~v;
    end
    @(negedge clk);
  endtask

  task automatic look(input bit [15:0] a, input string rq);
    cyc(1, a, 0, '0, '0, rq);
  endtask

  task automatic fill(input bit [15:0] fa, input int seed, input string rq);
    cyc(0, '0, 1, fa, pat(seed), rq);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R4: nothing valid after reset, including tag-0 addresses
    for (int k = 0; k < 8; k++) look(mk(0, k * 37, k), "R2");
    look(mk(0, 100, 0), "R4");
    cyc(0, mk(0, 0, 0), 0, '0, '0, "R5");

    // R8 / R10 / R6: first block lands in way 0, every byte readable
    fill(mk(3, 5, 0), 16, "R8");
    for (int k = 0; k < 8; k++) look(mk(3, 5, k), "R6");
    look(mk(4, 5, 2), "R7");
    cyc(0, mk(3, 5, 1), 0, '0, '0, "R5");

    // R10: second block of the set takes way 1, first one stays
    fill(mk(7, 5, 0), 17, "R10");
    look(mk(3, 5, 3), "R10");
    look(mk(7, 5, 6), "R10");

    // R11: hit on way 0 makes way 1 the victim
    look(mk(3, 5, 0), "R11");
    fill(mk(9, 5, 0), 18, "R11");
    look(mk(7, 5, 0), "R11");
    look(mk(9, 5, 4), "R11");
    look(mk(3, 5, 7), "R11");
    fill(mk(11, 5, 0), 19, "R11");
    look(mk(3, 5, 7), "R11");
    look(mk(11, 5, 2), "R11");

    // R9: lookup and fill to the same set in one cycle
    cyc(1, mk(11, 5, 1), 1, mk(13, 5, 0), pat(20), "R9");
    look(mk(9, 5, 1), "R9");
    look(mk(13, 5, 5), "R9");
    look(mk(11, 5, 5), "R9");
    // R11: same-cycle hit and fill, the fill's recency update wins
    cyc(1, mk(13, 5, 0), 1, mk(15, 5, 0), pat(21), "R11");
    look(mk(11, 5, 0), "R11");
    look(mk(13, 5, 0), "R11");
    look(mk(15, 5, 3), "R11");

    // R1: field boundaries at the top of the address space
    fill(16'hFFF8, 22, "R1");
    look(16'hFFFF, "R1");
    look(16'h07FF, "R1");
    look(16'hFFF7, "R1");
    look(mk(31, 255, 0), "R1");

    // R3 / R12: dense random traffic over four sets and three tags
    for (int n = 0; n < 600; n++) begin
      bit [15:0] la, fa;
      bit rq, fe;
      rq = ($urandom % 4) != 0;
      fe = ($urandom % 3) == 0;
      la = mk(1 + $urandom % 3, $urandom % 4, $urandom % 8);
      fa = mk(1 + $urandom % 3, $urandom % 4, 0);
      if (resident(fa)) fe = 0;
      cyc(rq, la, fe, fa, pat(30 + n), "R3");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule